// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on a two-wire serial bus. The bus has a clock line driven by the master and a shared data line that is pulled up and driven low in open-drain fashion. There is no select line: a transfer is framed by start and stop conditions and claims the device through a 7-bit address. Six of the address bits are a fixed prefix, and the lowest bit follows a strap pin, so two of these ports can share one bus.

After a write address, the first byte loads a memory address pointer. Any bytes that follow are stored in a 16-entry register file at the location the pointer selects. After a read address, the port sends out the register the pointer selects, and the master's acknowledge decides whether another byte follows. Bit 7 of the pointer byte turns on auto-increment for sequential reads and writes. When it is clear, every byte goes to the same register or comes from the same register.

Both bus lines are oversampled by the system clock through two-flop synchronizers. The data output is an output-enable, and asserting it pulls the line low. That output changes only while the bus clock is low.

Top module: `i2c_reg_port`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sda_oe_o` is 0 (the line is released).
- R2: An address byte is acknowledged (`sda_oe_o`=1 during the ninth clock) only when its upper seven bits equal binary 001000 followed by the level of `strap_i`. On a mismatch there is no acknowledge, and the port drives nothing until the next start condition.
- R3: In a write transfer, the byte after the address byte (bit 0 = 0 means write) loads the pointer. Each later byte is stored at register index pointer[3:0]. Every pointer byte and data byte is acknowledged.
- R4: In a read transfer (address bit 0 = 1), the port sends the register at pointer[3:0], most significant bit first. A 0 bit is sent as `sda_oe_o`=1, and a 1 bit as `sda_oe_o`=0.
- R5: With pointer bit 7 set, bits 6:0 of the pointer advance by one after every stored byte, so register indices wrap from 15 to 0. With bit 7 clear, the pointer holds.
- R6: The same increment rule applies after every byte sent in a read, so sequential reads return consecutive registers.
- R7: During the master's acknowledge slot after a read byte, the port releases the line. A 0 (ACK) in that slot starts the next byte. A 1 (NACK) ends the transfer, and the port stays released until the next start.
- R8: A start condition (data falls while the clock is high) begins a new address byte, including a repeated start in the middle of a transfer. A stop condition (data rises while the clock is high) returns the port to idle. Either condition releases the line.
- R9: `sda_oe_o` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 1 | Strap pin that sets the address LSB |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |

## Verification
The bench checks that the pointer wraps from index 15 to 0 under auto-increment. A design that carried into bit 4 without masking would write the wrong entry. It checks that a cleared increment flag sends repeated writes, and repeated reads, to a single register. A port that always incremented would spread those bytes across neighbours. Address bytes with a wrong prefix or a wrong strap bit are sent with data behind them: a port that acknowledged them or stored their bytes is caught by an idle-line monitor and by a later read-back. A stop in the middle of a byte, a repeated start after the pointer write, and a NACK that ends a read are also exercised. A port that kept its bit count across those events, or kept driving after the NACK, would corrupt the next transfer or hold the line low.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;
  localparam int BYTE_W      = 8;
  localparam int PTR_INC_BIT = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE_LVL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= IDLE_LVL;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= IDLE_LVL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign start_seen = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_seen  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_port_pkg::*;
#(
  parameter int         AW         = 4,
  parameter logic [5:0] DEV_PREFIX = 6'b001000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     raddr,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, ptr;
  logic              rw_flag, master_nack;
  logic              addr_ok, receiving;
  logic [PTR_INC_BIT-1:0] ptr_next;

  assign addr_ok   = (rx_sh[BYTE_W-1:1] == {DEV_PREFIX, strap});
  assign receiving = (phase == PH_ADDR) || (phase == PH_PTR) || (phase == PH_WDATA);
  assign ptr_next  = ptr[PTR_INC_BIT-1:0] + 1'b1;
  assign raddr     = ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      ptr         <= '0;
      rw_flag     <= 1'b0;
      master_nack <= 1'b1;
      sda_oe      <= 1'b0;
      we          <= 1'b0;
      waddr       <= '0;
      wdata       <= '0;
    end else begin
      we <= 1'b0;
      if (start_seen) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_seen) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (scl_rise && phase != PH_IDLE) begin
        if (bit_cnt < CNT_BYTE) begin
          if (receiving) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          if (phase == PH_RDATA) master_nack <= sda_s;
          bit_cnt <= CNT_ACK;
        end
      end else if (scl_fall && phase != PH_IDLE) begin
        if (bit_cnt == CNT_BYTE) begin
          // byte complete: decide the acknowledge slot
          unique case (phase)
            PH_ADDR: begin
              if (addr_ok) begin
                sda_oe  <= 1'b1;
                rw_flag <= rx_sh[0];
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_PTR: begin
              sda_oe <= 1'b1;
              ptr    <= rx_sh;
            end
            PH_WDATA: begin
              sda_oe <= 1'b1;
              we     <= 1'b1;
              waddr  <= ptr[AW-1:0];
              wdata  <= rx_sh;
              if (ptr[PTR_INC_BIT]) ptr[PTR_INC_BIT-1:0] <= ptr_next;
            end
            PH_RDATA: begin
              sda_oe <= 1'b0;
              if (ptr[PTR_INC_BIT]) ptr[PTR_INC_BIT-1:0] <= ptr_next;
            end
            default: ;
          endcase
        end else if (bit_cnt == CNT_ACK) begin
          // acknowledge slot over: move to the next byte
          bit_cnt <= '0;
          unique case (phase)
            PH_ADDR: begin
              if (rw_flag) begin
                phase  <= PH_RDATA;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                phase  <= PH_PTR;
                sda_oe <= 1'b0;
              end
            end
            PH_PTR: begin
              phase  <= PH_WDATA;
              sda_oe <= 1'b0;
            end
            PH_WDATA: sda_oe <= 1'b0;
            PH_RDATA: begin
              if (!master_nack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
              end
            end
            default: ;
          endcase
        end else if (phase == PH_RDATA) begin
          tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
          sda_oe <= ~tx_sh[BYTE_W-2];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port #(
  parameter int         REG_AW     = 4,
  parameter int         SYNC_STG   = 2,
  parameter logic [5:0] DEV_PREFIX = 6'b001000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic sda_oe_o
);
  localparam int DW = i2c_port_pkg::BYTE_W;

  logic [1:0]        lines_s;
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_seen, stop_seen;
  logic              mem_we;
  logic [REG_AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0]     mem_wdata, mem_rdata;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STG), .IDLE_LVL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_bus_events u_events (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  i2c_slave_engine #(.AW(REG_AW), .DEV_PREFIX(DEV_PREFIX)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .strap      (strap_i),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .rd_data    (mem_rdata),
    .raddr      (mem_raddr),
    .we         (mem_we),
    .waddr      (mem_waddr),
    .wdata      (mem_wdata),
    .sda_oe     (sda_oe_o)
  );

  i2c_reg_file #(.AW(REG_AW), .DW(DW)) u_regs (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_seen,
  input logic stop_seen,
  input logic sda_oe,
  input logic we
);
  // R1: line released on the first cycle out of reset
  a_r1_release_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  // R9: output moves only when the synchronized clock was low
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R8: start releases the line
  a_r8_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> !sda_oe);

  // R8: stop releases the line
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !sda_oe);

  // R3: register stores happen only in the clock-low phase
  a_r3_store_scl_low: assert property (@(posedge clk) disable iff (rst)
    we |-> !scl_s);
endmodule

bind i2c_reg_port i2c_reg_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .start_seen (start_seen),
  .stop_seen  (stop_seen),
  .sda_oe     (sda_oe_o),
  .we         (mem_we)
);

// File: tb/test_i2c_reg_port.sv
module test_i2c_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic oe;
  logic line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit quiet = 1;
  logic prev_oe = 1'b0;

  logic [7:0] mdl_mem [16];
  logic [7:0] mdl_ptr = 8'h00;

  assign line = sda_m & ~oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_port i_i2c_reg_port (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (line),
    .strap_i  (strap),
    .sda_oe_o (oe)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock monitors: idle line (R2, R7) and output timing (R9)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (quiet) chk_eq("R2/R7 idle line", int'(oe), 0);
      if (oe !== prev_oe) chk_eq("R9 oe change with scl high", int'(scl), 0);
    end
    prev_oe = oe;
  end

  function automatic logic [7:0] mdl_next(input logic [7:0] p);
    return p[7] ? {1'b1, p[6:0] + 7'd1} : p;
  endfunction

  function automatic void mdl_wr(input logic [7:0] v);
    mdl_mem[mdl_ptr[3:0]] = v;
    mdl_ptr = mdl_next(mdl_ptr);
  endfunction

  function automatic logic [7:0] mdl_rd();
    logic [7:0] v;
    v = mdl_mem[mdl_ptr[3:0]];
    mdl_ptr = mdl_next(mdl_ptr);
    return v;
  endfunction

  function automatic logic [7:0] addr_byte(input logic rd);
    return {6'b001000, strap, rd};
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clk_bit(input logic b, output logic seen_line, output logic seen_oe);
    sda_m = b;  wait_q();
    scl = 1'b1; wait_q();
    seen_line = line;
    seen_oe = oe;
    wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
    logic l, o;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(v[i], l, o);
      chk_eq({req, " slave silent on master bit"}, int'(o), 0);
    end
    clk_bit(1'b1, l, o);
    chk_eq({req, " ack slot"}, int'(o), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic nack, input string req);
    logic l, o;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, l, o);
      got[i] = l;
    end
    clk_bit(nack, l, o);
    chk_eq({req, " read byte"}, int'(got), int'(exp));
    chk_eq("R7 released in master ack slot", int'(o), 0);
  endtask

  task automatic wr_txn(input logic [7:0] p, input logic [7:0] d[$], input string req);
    quiet = 0;
    bus_start();
    send_byte(addr_byte(1'b0), 1'b1, "R2");
    send_byte(p, 1'b1, "R3 pointer");
    mdl_ptr = p;
    foreach (d[k]) begin
      send_byte(d[k], 1'b1, req);
      mdl_wr(d[k]);
    end
    bus_stop();
    quiet = 1;
  endtask

  task automatic rd_txn(input int n, input string req);
    quiet = 0;
    bus_start();
    send_byte(addr_byte(1'b1), 1'b1, "R2");
    for (int k = 0; k < n; k++) recv_byte(mdl_rd(), (k == n - 1), req);
    quiet = 1;
    chk_eq("R7 released after nack", int'(oe), 0);
    wait_q();
    bus_stop();
  endtask

  task automatic ptr_rd_txn(input logic [7:0] p, input int n, input string req);
    quiet = 0;
    bus_start();
    send_byte(addr_byte(1'b0), 1'b1, "R2");
    send_byte(p, 1'b1, "R3 pointer");
    mdl_ptr = p;
    bus_start(); // repeated start (R8)
    send_byte(addr_byte(1'b1), 1'b1, "R8 repeated start");
    for (int k = 0; k < n; k++) recv_byte(mdl_rd(), (k == n - 1), req);
    quiet = 1;
    wait_q();
    bus_stop();
  endtask

  initial begin
    logic [7:0] q[$];
    logic l, o;
    repeat (5) @(negedge clk);
    chk_eq("R1 oe in reset", int'(oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 oe after reset", int'(oe), 0);
    repeat (10) @(negedge clk);

    // R3/R5: fill all registers with auto-increment
    q = {};
    for (int i = 0; i < 16; i++) q.push_back(8'((i * 37 + 5) & 8'hFF));
    wr_txn(8'h80, q, "R5 inc write");

    // R4/R6/R8: pointer then repeated-start read of four
    ptr_rd_txn(8'h85, 4, "R6 seq read");

    // R5: flag clear keeps pointer on writes and reads
    wr_txn(8'h02, '{8'hA1, 8'hB2, 8'hC3}, "R5 hold write");
    ptr_rd_txn(8'h02, 2, "R5 hold read");

    // R2: wrong prefix then wrong strap bit, data must not land
    quiet = 1;
    bus_start();
    send_byte(8'h40, 1'b0, "R2 wrong prefix");
    send_byte(8'h80, 1'b0, "R2 after mismatch");
    send_byte(8'h55, 1'b0, "R2 after mismatch");
    bus_stop();
    bus_start();
    send_byte(8'h22, 1'b0, "R2 wrong strap");
    send_byte(8'h81, 1'b0, "R2 after mismatch");
    send_byte(8'h66, 1'b0, "R2 after mismatch");
    bus_stop();
    ptr_rd_txn(8'h80, 3, "R2 regs unchanged");

    // R2 strap=1, R5/R6 wrap from 15 to 0
    strap = 1'b1;
    repeat (4) @(negedge clk);
    wr_txn(8'h8F, '{8'h11, 8'h22}, "R5 wrap write");
    ptr_rd_txn(8'h8F, 2, "R6 wrap read");

    // R4: read straight from the current pointer
    rd_txn(3, "R4 read at pointer");

    // R8: stop in the middle of an address byte, then a clean transfer
    quiet = 0;
    bus_start();
    for (int i = 7; i >= 5; i--) clk_bit(addr_byte(1'b0) >> i, l, o);
    bus_stop();
    quiet = 1;
    repeat (4) @(negedge clk);
    rd_txn(2, "R8 after aborted byte");

    repeat (20) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule